// File: doc/BRIEF.md
# Dual-Mode Infrared Line Coder

This block sits between the serial bit stream of a UART and an infrared transceiver. On the transmit side it turns each UART bit into an optical drive signal. On the receive side it turns the detector output back into UART line levels. A character begins with a zero-valued start bit, as in any UART frame. Every zero bit produces emission and every one bit leaves the emitter dark. This keeps the idle line, the stop bits and the space between characters free of light.

Two line formats can be selected at run time. The narrow-pulse format sends a zero as a single short flash at the opening of the bit cell. The flash lasts 3/16 of the cell and is timed by a 16x oversample strobe, so the format scales to high bit rates. The carrier-keyed format sends a zero as a square-wave carrier that runs for the whole bit cell. It is meant for rates up to 19.2 kbaud with a 500 kHz carrier. The carrier is divided down from the system clock by a divisor at a port. The receiver stretches each detected flash to a full bit cell in narrow-pulse mode. In carrier-keyed mode it reports a zero for as long as carrier edges keep arriving.

Top module: `ir_line_coder`

## Requirements
- R1: After reset, and before any strobe arrives, `ir_tx` is 0 and `uart_rxd` is 1.
- R2: Bit cells are framed by `os_tick`. The first strobe after reset opens a cell, and after that every OS_RATE-th strobe (16 by default) opens one. `uart_txd` is captured at the strobe that opens a cell and holds for that whole cell.
- R3: In narrow-pulse mode (`mode_keyed` = 0), a captured zero drives `ir_tx` high in the clock cycle after the opening strobe. It stays high until PULSE_TICKS (3) more strobes have passed, then goes low for the rest of the cell.
- R4: A captured one leaves `ir_tx` at 0 for the whole cell, in either mode.
- R5: In carrier-keyed mode (`mode_keyed` = 1), a captured zero drives a square carrier on `ir_tx` for the whole cell. Each half period lasts `car_half` clock cycles. At the opening strobe the carrier restarts with a high half.
- R6: The carrier half period follows the value on `car_half`, so changing that port changes the number of high cycles per cell to match.
- R7: In narrow-pulse mode, a rising edge on `ir_rx` pulls `uart_rxd` low SYNC_STAGES+1 clock cycles later. It stays low until OS_RATE strobes have passed after the detection, and then it returns high.
- R8: In narrow-pulse mode, a new rising edge that arrives while `uart_rxd` is held low restarts the count of OS_RATE strobes.
- R9: In carrier-keyed mode, any edge on `ir_rx` pulls `uart_rxd` low SYNC_STAGES+1 cycles later. It stays low while edges keep coming, and it returns high once 2·GAP_PERIODS·`car_half` + 1 cycles pass with no further detected edge.
- R10: In carrier-keyed mode, two edges spaced more than the gap limit apart give two separate low stretches, with a high level between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_keyed | input | 1 | 0 selects the narrow-pulse format, 1 selects the carrier-keyed format |
| os_tick | input | 1 | Oversample strobe, OS_RATE strobes per bit cell |
| car_half | input | DIV_W | Carrier half period, in clock cycles |
| uart_txd | input | 1 | Serial transmit bit from the UART |
| ir_rx | input | 1 | Detector output from the transceiver, 1 means light |
| ir_tx | output | 1 | Emitter drive, 1 means light |
| uart_rxd | output | 1 | Recovered serial receive level for the UART |

## Verification
On the transmit side, each bit window opens with the strobe that starts a cell. The emitter reacts one clock cycle after that strobe, so the bench counts high samples over the whole window. It also records the index of the first high sample and expects it one cycle after the opening strobe. On the receive side, the output lags an input edge by SYNC_STAGES+1 cycles, which is two synchronizer stages plus one decode register. The bench places each edge so that its detection lands on a strobe cycle. The expected length of a low stretch then comes out exact: OS_RATE strobe periods, or the gap limit plus the span of the burst plus one. Inputs change and outputs are sampled only on the falling clock edge. Every window is aligned to a cell boundary before it starts.

// File: rtl/irlc_pkg.sv
package irlc_pkg;

   typedef enum logic {
      IRLC_PULSE = 1'b0,
      IRLC_KEYED = 1'b1
   } irlc_mode_e;

endpackage

// File: rtl/irlc_cell_timer.sv
module irlc_cell_timer #(
   parameter int OS_RATE = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       os_tick,
   output logic                       cell_open,
   output logic [$clog2(OS_RATE)-1:0] phase
);
   localparam int PH_W = $clog2(OS_RATE);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS_RATE - 1);

   logic [PH_W-1:0] phase_q;

   assign cell_open = os_tick && (phase_q == PH_LAST);
   assign phase     = phase_q;

   // Starting on the last phase makes the first strobe open a cell.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_LAST;
      end else if (os_tick) begin
         if (phase_q == PH_LAST) begin
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/irlc_carrier.sv
module irlc_carrier #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] car_half,
   output logic             carrier
);
   logic [DIV_W-1:0] cnt_q;
   logic             car_q;
   logic             half_done;

   // Widened compare: a zero divisor behaves like one.
   assign half_done = ({1'b0, cnt_q} + 1'b1) >= {1'b0, car_half};
   assign carrier   = car_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         car_q <= 1'b0;
      end else if (restart) begin
         cnt_q <= '0;
         car_q <= 1'b1;
      end else if (half_done) begin
         cnt_q <= '0;
         car_q <= ~car_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/irlc_tx_shaper.sv
module irlc_tx_shaper
   import irlc_pkg::*;
#(
   parameter int OS_RATE     = 16,
   parameter int PULSE_TICKS = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  irlc_mode_e                 mode,
   input  logic                       cell_open,
   input  logic [$clog2(OS_RATE)-1:0] phase,
   input  logic                       carrier,
   input  logic                       uart_txd,
   output logic                       ir_tx
);
   localparam int PH_W = $clog2(OS_RATE);
   localparam logic [PH_W-1:0] PULSE_END = PH_W'(PULSE_TICKS);

   logic bit_q;
   logic zero_cell;
   logic pulse_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b1;
      end else if (cell_open) begin
         bit_q <= uart_txd;
      end
   end

   assign zero_cell = ~bit_q;
   assign pulse_win = (phase < PULSE_END);

   always_comb begin
      unique case (mode)
         IRLC_KEYED: ir_tx = zero_cell & carrier;
         default:    ir_tx = zero_cell & pulse_win;
      endcase
   end

endmodule

// File: rtl/irlc_rx_recover.sv
module irlc_rx_recover
   import irlc_pkg::*;
#(
   parameter int OS_RATE     = 16,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int GAP_PERIODS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  irlc_mode_e       mode,
   input  logic             os_tick,
   input  logic [DIV_W-1:0] car_half,
   input  logic             ir_rx,
   output logic             uart_rxd
);
   localparam int HOLD_W = $clog2(OS_RATE + 1);
   localparam int MUL    = 2 * GAP_PERIODS;
   localparam int GAP_W  = DIV_W + $clog2(MUL) + 1;
   localparam logic [HOLD_W-1:0] HOLD_FULL = HOLD_W'(OS_RATE);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rx_s;
   logic                   rise_det;
   logic                   any_det;

   logic [HOLD_W-1:0]      hold_q;
   logic                   pulse_rxd_q;
   logic [GAP_W-1:0]       gap_q;
   logic [GAP_W-1:0]       gap_limit;
   logic                   keyed_rxd_q;

   // Synchronizer chain; its depth is set by a parameter
   generate
      if (SYNC_STAGES == 2) begin : g_sync2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], ir_rx};
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], ir_rx};
         end
      end
   endgenerate

   assign rx_s     = sync_q[SYNC_STAGES-1];
   assign rise_det = rx_s & ~prev_q;
   assign any_det  = rx_s ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= rx_s;
   end

   // Narrow-pulse decoder: stretch each flash to one bit cell.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         pulse_rxd_q <= 1'b1;
      end else if (rise_det) begin
         hold_q      <= HOLD_FULL;
         pulse_rxd_q <= 1'b0;
      end else if (os_tick && hold_q != '0) begin
         hold_q <= hold_q - 1'b1;
         if (hold_q == HOLD_W'(1)) begin
            pulse_rxd_q <= 1'b1;
         end
      end
   end

   // Carrier-keyed decoder: low while edges arrive within the gap limit.
   assign gap_limit = GAP_W'(car_half) * GAP_W'(MUL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q       <= '1;
         keyed_rxd_q <= 1'b1;
      end else if (any_det) begin
         gap_q       <= '0;
         keyed_rxd_q <= 1'b0;
      end else if (gap_q >= gap_limit) begin
         keyed_rxd_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   assign uart_rxd = (mode == IRLC_KEYED) ? keyed_rxd_q : pulse_rxd_q;

endmodule

// File: rtl/ir_line_coder.sv
module ir_line_coder
   import irlc_pkg::*;
#(
   parameter int OS_RATE     = 16,
   parameter int PULSE_TICKS = 3,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int GAP_PERIODS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_keyed,
   input  logic             os_tick,
   input  logic [DIV_W-1:0] car_half,
   input  logic             uart_txd,
   input  logic             ir_rx,
   output logic             ir_tx,
   output logic             uart_rxd
);
   localparam int PH_W = $clog2(OS_RATE);

   // Parameter checks at elaboration
   generate
      if (OS_RATE < 4 || (OS_RATE & (OS_RATE - 1)) != 0) begin : g_bad_os
         $error("OS_RATE must be a power of two, at least 4");
      end
      if (PULSE_TICKS < 1 || PULSE_TICKS >= OS_RATE) begin : g_bad_pulse
         $error("PULSE_TICKS must lie in 1..OS_RATE-1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DIV_W < 2 || GAP_PERIODS < 1) begin : g_bad_div
         $error("DIV_W must be at least 2 and GAP_PERIODS at least 1");
      end
   endgenerate

   irlc_mode_e      mode;
   logic            cell_open;
   logic [PH_W-1:0] phase;
   logic            carrier;

   assign mode = irlc_mode_e'(mode_keyed);

   irlc_cell_timer #(.OS_RATE(OS_RATE)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .os_tick   (os_tick),
      .cell_open (cell_open),
      .phase     (phase)
   );

   irlc_carrier #(.DIV_W(DIV_W)) u_carrier (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (cell_open),
      .car_half (car_half),
      .carrier  (carrier)
   );

   irlc_tx_shaper #(.OS_RATE(OS_RATE), .PULSE_TICKS(PULSE_TICKS)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .cell_open (cell_open),
      .phase     (phase),
      .carrier   (carrier),
      .uart_txd  (uart_txd),
      .ir_tx     (ir_tx)
   );

   irlc_rx_recover #(
      .OS_RATE     (OS_RATE),
      .DIV_W       (DIV_W),
      .SYNC_STAGES (SYNC_STAGES),
      .GAP_PERIODS (GAP_PERIODS)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .os_tick  (os_tick),
      .car_half (car_half),
      .ir_rx    (ir_rx),
      .uart_rxd (uart_rxd)
   );

endmodule

// File: rtl/irlc_checker.sv
module irlc_checker #(
   parameter int PULSE_TICKS = 3,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_keyed,
   input logic             os_tick,
   input logic [DIV_W-1:0] car_half,
   input logic             ir_rx,
   input logic             ir_tx,
   input logic             uart_rxd
);
   logic [DIV_W:0] hi_run_q;
   logic [7:0]     tick_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run_q <= '0;
      end else if (!ir_tx) begin
         hi_run_q <= '0;
      end else if (hi_run_q != '1) begin
         hi_run_q <= hi_run_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_run_q <= '0;
      end else if (!ir_tx || mode_keyed) begin
         tick_run_q <= '0;
      end else if (os_tick && tick_run_q != '1) begin
         tick_run_q <= tick_run_q + 1'b1;
      end
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!ir_tx && uart_rxd));

   // R3
   pulse_start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_keyed && !$past(mode_keyed) && $rose(ir_tx)) |-> $past(os_tick));

   // R3
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_keyed |-> (tick_run_q <= 8'(PULSE_TICKS)));

   // R5
   carrier_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_keyed && $stable(car_half) && car_half != '0)
         |-> (hi_run_q < ({1'b0, car_half} << 1)));

   // R7
   rx_fall_after_light_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_keyed && !$past(mode_keyed) && $fell(uart_rxd))
         |-> $past(ir_rx, SYNC_STAGES + 1));

endmodule

bind ir_line_coder irlc_checker #(
   .PULSE_TICKS (PULSE_TICKS),
   .DIV_W       (DIV_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_keyed (mode_keyed),
   .os_tick    (os_tick),
   .car_half   (car_half),
   .ir_rx      (ir_rx),
   .ir_tx      (ir_tx),
   .uart_rxd   (uart_rxd)
);

// File: tb/ir_line_coder_tb.sv
module ir_line_coder_tb;
   localparam int OS    = 16;
   localparam int TP    = 4;
   localparam int CELL  = OS * TP;
   localparam int DIV_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_keyed = 1'b0;
   logic os_tick = 1'b0;
   logic [DIV_W-1:0] car_half = 16'd4;
   logic uart_txd = 1'b1;
   logic ir_rx = 1'b0;
   logic ir_tx;
   logic uart_rxd;

   int n_chk = 0;
   int n_bad = 0;
   int tcnt = 0;
   int tick_idx = 0;
   int win_i, win_hi, win_first, win_lo;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ir_line_coder #(.OS_RATE(OS), .DIV_W(DIV_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_keyed(mode_keyed), .os_tick(os_tick),
      .car_half(car_half), .uart_txd(uart_txd), .ir_rx(ir_rx),
      .ir_tx(ir_tx), .uart_rxd(uart_rxd)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic win_clear();
      win_i = 0; win_hi = 0; win_first = -1; win_lo = 0;
   endtask

   // Sample outputs from the previous edge, then drive this cycle's inputs.
   task automatic step(input logic rxv);
      @(negedge clk);
      if (ir_tx) begin
         win_hi++;
         if (win_first < 0) win_first = win_i;
      end
      if (!uart_rxd) win_lo++;
      win_i++;
      ir_rx = rxv;
      os_tick = (tcnt == TP - 1);
      if (os_tick) tick_idx++;
      tcnt = (tcnt + 1) % TP;
   endtask

   task automatic align_cell();
      while (!(tcnt == 0 && (tick_idx % OS) == 0)) step(ir_rx);
   endtask

   function automatic int exp_hi(input logic b, input logic keyed, input int half);
      if (b) return 0;
      if (!keyed) return 3 * TP;
      // Cell cycles 0..CELL-TP-1 fall in the window; carrier restarts high.
      begin
         int h = 0;
         for (int c = 0; c < CELL - TP; c++) if (((c / half) % 2) == 0) h++;
         return h;
      end
   endfunction

   task automatic send_bit(input logic b, input bit chk, input string req);
      align_cell();
      uart_txd = b;
      win_clear();
      repeat (CELL) step(ir_rx);
      if (chk) begin
         check(req, win_hi, exp_hi(b, mode_keyed, int'(car_half)));
         if (!b) check(req, win_first, TP);
      end
   endtask

   initial begin
      int r;
      r = $urandom(32'd5150);
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1", int'(ir_tx), 0);
      check("R1", int'(uart_rxd), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(ir_tx), 0);
      check("R1", int'(uart_rxd), 1);

      // R2 R3 R4: narrow-pulse transmit, directed
      mode_keyed = 1'b0;
      send_bit(1'b0, 1, "R2_R3");
      send_bit(1'b1, 1, "R4");
      send_bit(1'b0, 1, "R3");
      send_bit(1'b0, 1, "R3");
      for (int k = 0; k < 40; k++) send_bit(1'($urandom & 1), 1, "R3_R4_rand");

      // R5 R4: carrier-keyed transmit
      mode_keyed = 1'b1;
      send_bit(1'b1, 1, "R4");
      send_bit(1'b0, 1, "R5");
      send_bit(1'b0, 1, "R5");
      for (int k = 0; k < 40; k++) send_bit(1'($urandom & 1), 1, "R5_R4_rand");

      // R6: a different divisor
      send_bit(1'b1, 1, "R6");
      car_half = 16'd6;
      send_bit(1'b1, 1, "R6");
      send_bit(1'b0, 1, "R6");
      send_bit(1'b1, 0, "R6");
      car_half = 16'd4;
      send_bit(1'b1, 1, "R4");

      // R7: single flash in narrow-pulse mode
      mode_keyed = 1'b0;
      align_cell();
      win_clear();
      step(1'b0); step(1'b1); step(1'b1);
      repeat (97) step(1'b0);
      check("R7", win_lo, CELL);

      // R8: second flash restarts the stretch
      align_cell();
      win_clear();
      step(1'b0); step(1'b1); step(1'b1);
      for (int c = 3; c < 33; c++) step(1'b0);
      step(1'b1); step(1'b1);
      for (int c = 35; c < 130; c++) step(1'b0);
      check("R8", win_lo, 96);

      // R9: carrier bursts in keyed mode (half period 4, limit 16)
      mode_keyed = 1'b1;
      for (int kk = 2; kk <= 8; kk += 6) begin
         logic lvl = 1'b0;
         align_cell();
         win_clear();
         step(1'b0);
         for (int c = 1; c < 100; c++) begin
            if (((c - 1) % 4) == 0 && ((c - 1) / 4) < kk) lvl = ~lvl;
            step(lvl);
         end
         check("R9", win_lo, 4 * (kk - 1) + 17);
      end

      // R10: two edges 20 cycles apart give two separate stretches
      align_cell();
      win_clear();
      step(1'b0);
      for (int c = 1; c < 21; c++) step(1'b1);
      for (int c = 21; c < 70; c++) begin
         step(1'b0);
         if (c == 22) check("R10", int'(uart_rxd), 1);
      end
      check("R10", win_lo, 34);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule